// File: doc/BRIEF.md
# Enable-Latched Address Static Memory

This block is a synthesizable model of a 1024-word by 4-bit static memory whose accesses are framed by an active-low chip enable. The address is taken into an internal register when the enable falls. After that the address pins are free to change until the next access. The shared bidirectional data bus is split into a data input, a data output and an output-enable flag, so the memory can sit inside a single chip next to the logic that uses it.

A free-running sampling clock, much faster than the strobes, observes the enable and write strobes through two-stage synchronizers. Strobe edges are found by comparing each synchronized sample with the one before it. Reads drive the bus only while the enable is low and the write strobe is high. A write is committed when the period in which both strobes are low ends, using the data sampled just before that end. The array is organised as 64 rows of 64 bits, and each row holds sixteen 4-bit groups.

Top module: `strobe_latched_sram`

## Requirements
- R1: Every one of the 1024 locations keeps the 4-bit word last written to it. A later read of that address returns exactly that word.
- R2: The address is captured on the synchronized falling edge of `ce_n`. Changes on `addr` after that edge do not change which location the current access reads or writes.
- R3: With `ce_n` low and `we_n` high, `dout_en` goes high and `dout` carries the stored word at the latched address no later than four clock edges after `ce_n` falls. Both stay that way while the strobes do not change.
- R4: Within three clock edges after `ce_n` goes high, `dout_en` is low. Whenever `dout_en` is low, `dout` is 0.
- R5: Within three clock edges after `we_n` goes low while `ce_n` is low, `dout_en` is low.
- R6: When `we_n` rises while `ce_n` is still low after a period in which both were low, the value on `din` just before that rise is written to the latched address.
- R7: When `ce_n` rises while `we_n` is low, the write is committed at the `ce_n` rise using the `din` value just before it. A later rise of `we_n` while `ce_n` is high writes nothing.
- R8: With `we_n` held low across several `ce_n` low pulses, each pulse writes its own `din` value to the address latched at that pulse's falling edge.
- R9: Address bits [9:4] select one of 64 rows and bits [3:0] select one of sixteen 4-bit groups in that row. A write changes only its own group.
- R10: After reset, `dout_en` is low and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; its falling edge latches the address |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 10 | Word address |
| din | input | 4 | Write data from the shared bus |
| dout | output | 4 | Read data, 0 when not driven |
| dout_en | output | 1 | High when the memory drives the shared bus |

## Verification
The assertions check on every cycle that the latched address changes only at a detected enable fall and then takes the synchronized address. They also check that the bus is released one cycle after a synchronized high enable or a low write strobe, and that a write commit never occurs on two cycles in a row. The bench scenarios show the things that need a memory model: stored contents across the whole array, which of the two write endings carries the data, that addresses changed after the latch have no effect, and that chained writes with the write strobe held low land in separate locations.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef struct packed {
    logic ce_n;
    logic we_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              rst_n_int,
  output logic              ce_q,
  output logic              we_q,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] wdata,
  output logic              wr_commit,
  output logic              rd_live
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  strobe_t                stb_pipe [SYNC_STAGES];
  logic [ADDR_W-1:0]      adr_pipe [SYNC_STAGES];
  logic [DATA_W-1:0]      dat_pipe [SYNC_STAGES];
  strobe_t                stb_prev;
  logic [DATA_W-1:0]      dat_prev;
  logic [ADDR_W-1:0]      lat_addr_nxt;
  logic                   ce_fall;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_int) begin
          if (!rst_n_int) begin
            stb_pipe[s] <= STROBE_IDLE;
            adr_pipe[s] <= '0;
            dat_pipe[s] <= '0;
          end else begin
            stb_pipe[s] <= '{ce_n: ce_n, we_n: we_n};
            adr_pipe[s] <= addr;
            dat_pipe[s] <= din;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n_int) begin
          if (!rst_n_int) begin
            stb_pipe[s] <= STROBE_IDLE;
            adr_pipe[s] <= '0;
            dat_pipe[s] <= '0;
          end else begin
            stb_pipe[s] <= stb_pipe[s-1];
            adr_pipe[s] <= adr_pipe[s-1];
            dat_pipe[s] <= dat_pipe[s-1];
          end
        end
      end
    end
  endgenerate

  assign ce_q = stb_pipe[SYNC_STAGES-1].ce_n;
  assign we_q = stb_pipe[SYNC_STAGES-1].we_n;

  always_comb begin
    ce_fall      = stb_prev.ce_n & ~ce_q;
    wr_commit    = ~stb_prev.ce_n & ~stb_prev.we_n & (ce_q | we_q);
    rd_live      = ~stb_prev.ce_n & ~ce_q & we_q;
    lat_addr_nxt = lat_addr;
    if (ce_fall) lat_addr_nxt = adr_pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      stb_prev <= STROBE_IDLE;
      dat_prev <= '0;
      lat_addr <= '0;
    end else begin
      stb_prev <= stb_pipe[SYNC_STAGES-1];
      dat_prev <= dat_pipe[SYNC_STAGES-1];
      lat_addr <= lat_addr_nxt;
    end
  end

  assign wdata = dat_prev;

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ce_fall |=> $stable(lat_addr));
  p_latch_take_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    ce_fall |=> lat_addr == $past(adr_pipe[SYNC_STAGES-1]));
  p_commit_single_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_commit |=> !wr_commit);
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 4,
  parameter int COL_BITS = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] adr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROW_BITS = ADDR_W - COL_BITS;
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int ROW_W    = DATA_W << COL_BITS;

  logic [ROW_W-1:0]    rows [ROWS];
  logic [ROW_BITS-1:0] row_sel;
  logic [COL_BITS-1:0] col_sel;

  assign row_sel = adr[ADDR_W-1:COL_BITS];
  assign col_sel = adr[COL_BITS-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) rows[row_sel][col_sel*DATA_W +: DATA_W] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= rows[row_sel][col_sel*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/strobe_latched_sram.sv
module strobe_latched_sram #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 4,
  parameter int COL_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              rst_n_int;
  logic              ce_q;
  logic              we_q;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] wdata;
  logic              wr_commit;
  logic              rd_live;
  logic [DATA_W-1:0] rdata;
  logic              oe_r;
  logic              oe_nxt;

  sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .din(din), .rst_n_int(rst_n_int),
    .ce_q(ce_q), .we_q(we_q), .lat_addr(lat_addr), .wdata(wdata),
    .wr_commit(wr_commit), .rd_live(rd_live)
  );

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_BITS(COL_BITS)) u_array (
    .clk(clk), .wr_en(wr_commit), .rd_en(rd_live),
    .adr(lat_addr), .wdata(wdata), .rdata(rdata)
  );

  always_comb oe_nxt = rd_live;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) oe_r <= 1'b0;
    else            oe_r <= oe_nxt;
  end

  assign dout_en = oe_r;
  assign dout    = oe_r ? rdata : '0;

  p_z_idle_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    ce_q |=> !dout_en);
  p_z_write_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    !we_q |=> !dout_en);
endmodule

// File: tb/tb_strobe_latched_sram.sv
module tb_strobe_latched_sram;
  localparam int CLK_NS   = 10;
  localparam int WATCHDOG = 190000;
  localparam int GAP      = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce_n, we_n;
  logic [9:0] addr;
  logic [3:0] din;
  logic [3:0] dout;
  logic       dout_en;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  logic [3:0] model [1024];

  strobe_latched_sram dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: act %0d cycles exp < %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] other_addr(input logic [9:0] a);
    return a ^ 10'h2A5;
  endfunction

  // mode 0: write strobe ends the write (R6); mode 1: enable ends it (R7)
  task automatic do_write(input logic [9:0] a, input logic [3:0] d, input bit mode);
    addr = a; din = d;
    if (mode == 1'b0) begin
      ce_n = 1'b0; tick(GAP);
      addr = other_addr(a);
      we_n = 1'b0; tick(GAP);
      we_n = 1'b1; tick(GAP);
      ce_n = 1'b1; tick(GAP);
    end else begin
      we_n = 1'b0; tick(GAP);
      ce_n = 1'b0; tick(GAP);
      addr = other_addr(a);
      ce_n = 1'b1; tick(GAP);
      din  = ~d;
      we_n = 1'b1; tick(GAP);
    end
    model[a] = d;
  endtask

  task automatic do_read(input logic [9:0] a, input string req);
    addr = a; we_n = 1'b1; ce_n = 1'b0;
    tick(2);
    addr = other_addr(a);
    tick(3);
    check(dout_en === 1'b1, "R3 dout_en", int'(dout_en), 1);
    check(dout === model[a], req, int'(dout), int'(model[a]));
    ce_n = 1'b1;
    tick(3);
    check(dout_en === 1'b0 && dout === 4'h0, "R4 release", int'({dout_en, dout}), 0);
    tick(1);
  endtask

  initial begin
    process::self().srandom(32'd1997);
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    tick(3);
    check(dout_en === 1'b0 && dout === 4'h0, "R10 reset", int'({dout_en, dout}), 0);
    rst_n = 1'b1;
    tick(4);
    check(dout_en === 1'b0, "R10 after release", int'(dout_en), 0);

    // R1 R9: fill every location, alternating write endings, then read back
    for (int a = 0; a < 1024; a++)
      do_write(a[9:0], 4'($urandom), a[0]);
    for (int a = 0; a < 1024; a++)
      do_read(a[9:0], "R1 R9 readback");

    // R9: one group in a row changes, its neighbours keep their words
    do_write(10'h3F5, ~model[10'h3F5], 1'b0);
    do_read(10'h3F4, "R9 left neighbour");
    do_read(10'h3F5, "R9 target group");
    do_read(10'h3F6, "R9 right neighbour");
    do_read(10'h3E5, "R9 other row");

    // R6 R7 directed: extreme data and address values
    do_write(10'h000, 4'hF, 1'b0); do_read(10'h000, "R6 low address");
    do_write(10'h3FF, 4'h0, 1'b1); do_read(10'h3FF, "R7 high address");

    // R5: write strobe lowered mid-read releases the bus, then its rise commits din
    begin
      logic [9:0] a5 = 10'h155;
      logic [3:0] d5 = ~model[10'h155];
      addr = a5; we_n = 1'b1; ce_n = 1'b0; tick(GAP + 1);
      check(dout_en === 1'b1, "R3 before write strobe", int'(dout_en), 1);
      din = d5; we_n = 1'b0; tick(3);
      check(dout_en === 1'b0, "R5 bus released", int'(dout_en), 0);
      we_n = 1'b1; tick(GAP + 1);
      check(dout_en === 1'b1 && dout === d5, "R6 read after late strobe", int'(dout), int'(d5));
      ce_n = 1'b1; tick(GAP);
      model[a5] = d5;
      do_read(a5, "R6 stored");
    end

    // R8: write strobe held low across several enable pulses
    begin
      logic [9:0] ca [4];
      logic [3:0] cd [4];
      we_n = 1'b0; tick(GAP);
      for (int k = 0; k < 4; k++) begin
        ca[k] = 10'(($urandom % 256) * 4 + k);
        cd[k] = 4'($urandom);
        addr = ca[k]; din = cd[k]; ce_n = 1'b0; tick(GAP);
        addr = other_addr(ca[k]); tick(1);
        ce_n = 1'b1; tick(GAP);
        check(dout_en === 1'b0, "R5 chained", int'(dout_en), 0);
        model[ca[k]] = cd[k];
      end
      we_n = 1'b1; tick(GAP);
      for (int k = 0; k < 4; k++) do_read(ca[k], "R8 chained write");
    end

    // R2 R1: random mix of writes and reads
    for (int n = 0; n < 600; n++) begin
      logic [9:0] ra = 10'($urandom);
      if ($urandom % 2 == 0) do_write(ra, 4'($urandom), 1'($urandom));
      else                   do_read(ra, "R2 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule